// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Carry Flags

This block is the purely combinational datapath core of a small accumulator-oriented processor. It receives the accumulator byte, a second operand fetched from memory, the current carry flag and a four-bit operation code. It returns the computed byte, new carry, zero and negative flags, and a write-enable that tells the surrounding control logic whether the byte should be stored back into the accumulator.

Addition and subtraction exist only in carry-chained form. On subtraction a set carry means "no borrow", so software sets carry before a single-byte subtract and clears it before a single-byte add. Compare runs the subtraction path but only updates flags. Shifts, rotates, increment and decrement act on the accumulator operand alone.

The block holds no state. Register storage, instruction decode, memory access, the overflow flag and decimal arithmetic belong elsewhere.

Top module: `acc_alu`

## Requirements
- R1: Op code 0 (add with carry): {carry_o, result_o} equals acc_i + opnd_i + carry_i as a 9-bit sum.
- R2: Op code 1 (subtract with borrow): result_o equals (acc_i - opnd_i - (1 - carry_i)) mod 256. carry_o is 1 exactly when no borrow occurred, that is, when acc_i >= opnd_i + (1 - carry_i).
- R3: Op codes 2, 3 and 4 give the bitwise AND, OR and exclusive-OR of acc_i and opnd_i. For example, AND of 8'hDE with 8'h0F gives 8'h0E.
- R4: Op code 5 shifts acc_i left by one bit. Op code 6 is a logical right shift by one bit. Both fill the vacated bit with 0 and place the bit shifted out (bit 7 for a left shift, bit 0 for a right shift) in carry_o.
- R5: Op code 7 is an arithmetic right shift. Bit 7 of the result equals bit 7 of acc_i, and carry_o receives bit 0 of acc_i.
- R6: Op code 8 rotates left through carry: carry_i enters bit 0 and bit 7 goes to carry_o. Op code 9 rotates right through carry: carry_i enters bit 7 and bit 0 goes to carry_o.
- R7: Op code 10 gives (acc_i + 1) mod 256 and op code 11 gives (acc_i - 1) mod 256. Both pass carry_i unchanged to carry_o.
- R8: Op code 12 (compare) drives acc_we_o low. It sets zero_o = (acc_i == opnd_i) and carry_o = (acc_i >= opnd_i), and negative_o is bit 7 of (acc_i - opnd_i) mod 256.
- R9: For every op that writes a result, zero_o is 1 exactly when result_o is 0, and negative_o equals result_o bit 7.
- R10: acc_we_o is 1 for op codes 0 through 11. It is 0 for compare and for the unused codes 13 to 15. The unused codes also return result_o = acc_i and carry_o = carry_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Memory operand |
| carry_i | input | 1 | Current carry flag |
| op_i | input | 4 | Operation code |
| result_o | output | 8 | Computed byte |
| carry_o | output | 1 | Updated carry flag |
| zero_o | output | 1 | Updated zero flag |
| negative_o | output | 1 | Updated negative flag |
| acc_we_o | output | 1 | Accumulator write-enable |

## Verification
Directed cases target the points where carry logic goes wrong:
- An add that wraps from 8'hFF to zero separates the carry-out from the zero flag.
- Equal, greater and lesser compares separate the carry from the zero encoding.
- Subtractions with carry both set and clear show whether the borrow sense is inverted.
- Rotates with a set incoming carry show whether the old carry reaches the vacated end or the fill is a constant.
- A negative arithmetic shift separates it from a logical shift.
- Increment of 8'hFF and decrement of zero, each with carry set, show both the wrap and that carry is left alone.

Random operands across all sixteen codes then cover the remaining combinations of operands and flags.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADDC = 4'd0,
        OP_SUBB = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_SHL  = 4'd5,
        OP_SHR  = 4'd6,
        OP_SAR  = 4'd7,
        OP_RCL  = 4'd8,
        OP_RCR  = 4'd9,
        OP_INC  = 4'd10,
        OP_DEC  = 4'd11,
        OP_CMP  = 4'd12,
        OP_RS13 = 4'd13,
        OP_RS14 = 4'd14,
        OP_RS15 = 4'd15
    } alu_op_e;

endpackage

// File: rtl/acc_alu_adder.sv
// Shared carry-chain adder: {cout, sum} = a + b + cin.
module acc_alu_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    localparam int SW = W + 1;

    logic [SW-1:0] full;

    always_comb begin
        full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        sum  = full[W-1:0];
        cout = full[W];
    end
endmodule

// File: rtl/acc_alu_logic.sv
// Bitwise unit; structure repeats per bit.
module acc_alu_logic #(
    parameter int W = 8
) (
    input  logic [W-1:0]           a,
    input  logic [W-1:0]           b,
    input  acc_alu_pkg::alu_op_e   op,
    output logic [W-1:0]           res
);
    import acc_alu_pkg::*;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            unique case (op)
                OP_AND:  res[i] = a[i] & b[i];
                OP_OR:   res[i] = a[i] | b[i];
                default: res[i] = a[i] ^ b[i];
            endcase
        end
    end
endmodule

// File: rtl/acc_alu_shift.sv
// One-position shifts and rotates through carry on the accumulator operand.
module acc_alu_shift #(
    parameter int W = 8
) (
    input  logic [W-1:0]           a,
    input  logic                   cin,
    input  acc_alu_pkg::alu_op_e   op,
    output logic [W-1:0]           res,
    output logic                   cout
);
    import acc_alu_pkg::*;

    localparam int MSB = W - 1;

    logic left;
    logic fill;

    always_comb begin
        left = (op == OP_SHL) || (op == OP_RCL);
        unique case (op)
            OP_SAR:          fill = a[MSB];
            OP_RCL, OP_RCR:  fill = cin;
            default:         fill = 1'b0;
        endcase
        if (left) begin
            res  = {a[MSB-1:0], fill};
            cout = a[MSB];
        end else begin
            res  = {fill, a[MSB:1]};
            cout = a[0];
        end
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
    parameter int W = 8
) (
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] opnd_i,
    input  logic         carry_i,
    input  logic [3:0]   op_i,
    output logic [W-1:0] result_o,
    output logic         carry_o,
    output logic         zero_o,
    output logic         negative_o,
    output logic         acc_we_o
);
    import acc_alu_pkg::*;

    alu_op_e       op;
    logic [W-1:0]  add_b;
    logic          add_cin;
    logic [W-1:0]  add_sum;
    logic          add_cout;
    logic [W-1:0]  log_res;
    logic [W-1:0]  sh_res;
    logic          sh_cout;

    assign op = alu_op_e'(op_i);

    // Operand steering into the one shared adder.
    always_comb begin
        add_b   = opnd_i;
        add_cin = carry_i;
        unique case (op)
            OP_SUBB: add_b = ~opnd_i;
            OP_CMP: begin
                add_b   = ~opnd_i;
                add_cin = 1'b1;
            end
            OP_INC: begin
                add_b   = '0;
                add_cin = 1'b1;
            end
            OP_DEC: begin
                add_b   = '1;
                add_cin = 1'b0;
            end
            default: ;
        endcase
    end

    acc_alu_adder #(.W(W)) u_add (
        .a    (acc_i),
        .b    (add_b),
        .cin  (add_cin),
        .sum  (add_sum),
        .cout (add_cout)
    );

    acc_alu_logic #(.W(W)) u_log (
        .a   (acc_i),
        .b   (opnd_i),
        .op  (op),
        .res (log_res)
    );

    acc_alu_shift #(.W(W)) u_sh (
        .a    (acc_i),
        .cin  (carry_i),
        .op   (op),
        .res  (sh_res),
        .cout (sh_cout)
    );

    // Result, carry and write-enable selection.
    always_comb begin
        result_o = acc_i;
        carry_o  = carry_i;
        acc_we_o = 1'b1;
        unique case (op)
            OP_ADDC, OP_SUBB: begin
                result_o = add_sum;
                carry_o  = add_cout;
            end
            OP_CMP: begin
                result_o = add_sum;
                carry_o  = add_cout;
                acc_we_o = 1'b0;
            end
            OP_INC, OP_DEC: result_o = add_sum;
            OP_AND, OP_OR, OP_XOR: result_o = log_res;
            OP_SHL, OP_SHR, OP_SAR, OP_RCL, OP_RCR: begin
                result_o = sh_res;
                carry_o  = sh_cout;
            end
            default: acc_we_o = 1'b0;
        endcase
        zero_o     = ~|result_o;
        negative_o = result_o[W-1];
    end
endmodule

// File: rtl/acc_alu_checker.sv
module acc_alu_checker #(
    parameter int W = 8
) (
    input logic [W-1:0] acc_i,
    input logic [W-1:0] opnd_i,
    input logic         carry_i,
    input logic [3:0]   op_i,
    input logic [W-1:0] result_o,
    input logic         carry_o,
    input logic         zero_o,
    input logic         negative_o,
    input logic         acc_we_o
);
    always_comb begin
        if (op_i == 4'd0) begin
            p_addc_sum_r1: assert ({carry_o, result_o} ==
                ({1'b0, acc_i} + {1'b0, opnd_i} + {{W{1'b0}}, carry_i}));
        end
        if (op_i == 4'd7) begin
            p_sar_sign_r5: assert (result_o[W-1] == acc_i[W-1] && carry_o == acc_i[0]);
        end
        if (op_i == 4'd10 || op_i == 4'd11) begin
            p_step_carry_r7: assert (carry_o == carry_i);
        end
        if (op_i == 4'd12) begin
            p_cmp_flags_r8: assert (!acc_we_o && zero_o == (acc_i == opnd_i)
                                    && carry_o == (acc_i >= opnd_i));
        end
        if (acc_we_o) begin
            p_zero_neg_r9: assert (zero_o == (result_o == '0) && negative_o == result_o[W-1]);
        end
        p_write_en_r10: assert (acc_we_o == (op_i < 4'd12));
    end
endmodule

bind acc_alu acc_alu_checker #(.W(W)) u_chk (
    .acc_i      (acc_i),
    .opnd_i     (opnd_i),
    .carry_i    (carry_i),
    .op_i       (op_i),
    .result_o   (result_o),
    .carry_o    (carry_o),
    .zero_o     (zero_o),
    .negative_o (negative_o),
    .acc_we_o   (acc_we_o)
);

// File: tb/acc_alu_bench.sv
module acc_alu_bench;
    logic       clk = 1'b0;
    logic [7:0] acc_i = '0;
    logic [7:0] opnd_i = '0;
    logic       carry_i = 1'b0;
    logic [3:0] op_i = '0;
    logic [7:0] result_o;
    logic       carry_o, zero_o, negative_o, acc_we_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    acc_alu u_acc_alu (
        .acc_i(acc_i), .opnd_i(opnd_i), .carry_i(carry_i), .op_i(op_i),
        .result_o(result_o), .carry_o(carry_o), .zero_o(zero_o),
        .negative_o(negative_o), .acc_we_o(acc_we_o)
    );

    function automatic string tag(input logic [3:0] op);
        case (op)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2, 4'd3, 4'd4: return "R3";
            4'd5, 4'd6: return "R4";
            4'd7: return "R5";
            4'd8, 4'd9: return "R6";
            4'd10, 4'd11: return "R7";
            4'd12: return "R8";
            default: return "R10";
        endcase
    endfunction

    // Expected {we, n, z, c, result} from the requirements.
    function automatic logic [11:0] model(input logic [7:0] a, input logic [7:0] m,
                                          input logic c, input logic [3:0] op);
        logic [8:0] s;
        logic [7:0] r;
        logic       cy;
        logic       we;
        logic       z;
        int         d;
        we = 1'b1;
        cy = c;
        r  = a;
        case (op)
            4'd0: begin s = 9'(a) + 9'(m) + 9'(c); r = s[7:0]; cy = s[8]; end
            4'd1: begin d = int'(a) - int'(m) - (c ? 0 : 1); r = 8'(d); cy = (d >= 0); end
            4'd2: r = a & m;
            4'd3: r = a | m;
            4'd4: r = a ^ m;
            4'd5: begin r = {a[6:0], 1'b0}; cy = a[7]; end
            4'd6: begin r = {1'b0, a[7:1]}; cy = a[0]; end
            4'd7: begin r = {a[7], a[7:1]}; cy = a[0]; end
            4'd8: begin r = {a[6:0], c}; cy = a[7]; end
            4'd9: begin r = {c, a[7:1]}; cy = a[0]; end
            4'd10: r = a + 8'd1;
            4'd11: r = a - 8'd1;
            4'd12: begin r = a - m; cy = (a >= m); we = 1'b0; end
            default: we = 1'b0;
        endcase
        z = (op == 4'd12) ? (a == m) : (r == 8'd0);
        return {we, r[7], z, cy, r};
    endfunction

    task automatic apply(input logic [7:0] a, input logic [7:0] m,
                         input logic c, input logic [3:0] op);
        logic [11:0] exp_v;
        logic [11:0] act_v;
        @(posedge clk);
        acc_i = a; opnd_i = m; carry_i = c; op_i = op;
        @(negedge clk);
        exp_v = model(a, m, c, op);
        act_v = {acc_we_o, negative_o, zero_o, carry_o, result_o};
        n_tests++;
        if (act_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s op=%0d a=%h m=%h c=%b actual{we,n,z,c,res}=%h expected=%h",
                     tag(op), op, a, m, c, act_v, exp_v);
        end
        if (exp_v[11]) begin
            // R9: zero and negative flags follow the written byte
            n_tests++;
            if (zero_o !== (result_o == 8'd0) || negative_o !== result_o[7]) begin
                n_fail++;
                $display("FAIL R9 op=%0d actual z=%b n=%b res=%h expected z=%b n=%b",
                         op, zero_o, negative_o, result_o, (result_o == 8'd0), result_o[7]);
            end
        end
    endtask

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'h1357);
        repeat (2) @(posedge clk);
        apply(8'h00, 8'h00, 1'b0, 4'd0);   // R1 idle-level inputs give zero
        apply(8'hFF, 8'h01, 1'b0, 4'd0);   // R1 wrap: carry and zero
        apply(8'h7F, 8'h00, 1'b1, 4'd0);   // R1 carry-in counted
        apply(8'h50, 8'h50, 1'b1, 4'd1);   // R2 no borrow in
        apply(8'h10, 8'h20, 1'b1, 4'd1);   // R2 borrow out
        apply(8'h50, 8'h50, 1'b0, 4'd1);   // R2 borrow in
        apply(8'hDE, 8'h0F, 1'b0, 4'd2);   // R3 mask
        apply(8'hA0, 8'h01, 1'b0, 4'd3);   // R3 force bit
        apply(8'h5A, 8'h5A, 1'b0, 4'd4);   // R3 xor equal
        apply(8'h81, 8'h00, 1'b1, 4'd5);   // R4 left
        apply(8'h81, 8'h00, 1'b1, 4'd6);   // R4 logical right
        apply(8'h81, 8'h00, 1'b0, 4'd7);   // R5 sign kept
        apply(8'h02, 8'h00, 1'b1, 4'd9);   // R6 carry into bit 7
        apply(8'h80, 8'h00, 1'b1, 4'd8);   // R6 carry into bit 0
        apply(8'hFF, 8'h00, 1'b1, 4'd10);  // R7 wrap up, carry held
        apply(8'h00, 8'h00, 1'b1, 4'd11);  // R7 wrap down, carry held
        apply(8'h50, 8'h50, 1'b0, 4'd12);  // R8 equal
        apply(8'h60, 8'h50, 1'b0, 4'd12);  // R8 greater
        apply(8'h40, 8'h50, 1'b1, 4'd12);  // R8 less
        apply(8'h33, 8'h44, 1'b1, 4'd13);  // R10 unused code
        apply(8'h00, 8'h44, 1'b0, 4'd15);  // R10 unused code
        for (int i = 0; i < 3000; i++) begin
            apply(8'($urandom), 8'($urandom), 1'($urandom), 4'($urandom));
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule